// File: doc/BRIEF.md
# Byte-Parity Packet Sender with Portion Re-send

This block is the transmit end of an end-to-end link that protects every payload byte with its own parity bit. A client hands it a 32-bit word together with a 5-bit source and a 5-bit destination address. The block numbers the packet itself and builds a 64-bit flit. The flit holds a 28-bit header and a 36-bit payload in which each byte is followed by its parity bit. The flit is presented on a registered parallel output with a valid/ready handshake.

The receiver never acknowledges good packets; it only returns negative acknowledgements. The sender keeps the eight most recently issued packets in a small RAM indexed by the low bits of the packet number. A NAK names a packet number, the address of the node that complains and a portion number. The block then re-sends only that 9-bit byte-plus-parity portion, tagged with the portion number. A NAK flagged as a lost-packet report makes the block re-send the whole stored payload instead. A NAK that cannot be served from the store sets a sticky error flag. Pending re-sends always win over new packets.

Top module: `bpt_sender`

## Requirements
- R1: The flit header uses these bit positions: source address [63:59], destination address [58:54], packet number [53:44], portion number [43:42], control [41:36]. A new packet carries portion number 0 and control 0.
- R2: Payload bits [35:0] hold four 9-bit groups, most significant first. Group k (k=0..3) holds data byte in_data[31-8k -: 8] followed by one parity bit. The parity bit is 1 when that byte has an odd number of ones and 0 when it has an even number.
- R3: The first new packet after reset is numbered 0. Each new packet accepted afterwards gets the previous number plus one, modulo 1024.
- R4: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_flit stays unchanged on the next cycle.
- R5: A portion NAK (nak_whole=0) that hits the store produces exactly one flit. That flit has the stored source, destination and packet number, portion number = nak_part and control 6'b000001. Its payload bits [8:0] hold group nak_part as defined in R2, and bits [35:9] are zero.
- R6: A lost-packet NAK (nak_whole=1) that hits the store produces one flit with the stored header fields, portion number 0, control 6'b000010 and the full 36-bit payload of R2.
- R7: While a NAK is offered or pending, in_ready is 0. A re-send is therefore emitted before any new packet offered at the same time.
- R8: The store holds the last 8 new packets. A NAK hits only when its packet number is one of those 8 and nak_src equals that packet's destination address. An older packet overwritten by packet number + 8 misses.
- R9: A NAK that misses emits no flit and sets nak_err. nak_err then stays 1 until reset.
- R10: The block takes one NAK at a time: nak_ready is 0 in the cycle after a NAK is accepted.
- R11: After reset out_valid and nak_err are 0, nak_ready and in_ready are 1, and the store is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | New payload offered |
| in_ready | output | 1 | New payload accepted this cycle when in_valid is 1 |
| in_data | input | 32 | Payload word |
| in_src | input | 5 | Source address of the new packet |
| in_dst | input | 5 | Destination address of the new packet |
| nak_valid | input | 1 | NAK offered |
| nak_ready | output | 1 | NAK accepted this cycle when nak_valid is 1 |
| nak_src | input | 5 | Address of the node that raised the NAK |
| nak_pnum | input | 10 | Packet number named by the NAK |
| nak_part | input | 2 | Portion number named by the NAK |
| nak_whole | input | 1 | 1: packet reported lost, re-send the whole payload |
| out_valid | output | 1 | Flit valid |
| out_ready | input | 1 | Downstream accepts the flit |
| out_flit | output | 64 | Header and payload |
| nak_err | output | 1 | Sticky flag: a NAK could not be served |

## Verification
The bench stalls the output at random while new packets and NAKs arrive. A flit that changed under back-pressure, or that was sent twice after a dropped NAK, shows up as a mismatch against the expected flit order. NAKs name each of the four portions, so a wrong group select or shift would return the wrong byte. They also name a packet just past the eight-entry window and a packet whose destination does not match; a store that ignored its tag or address check would re-send stale data instead of raising the error. A NAK and a new packet are offered in the same cycle to expose a priority inversion. The packet counter runs past 1023, so a counter that fails to wrap, or a store whose tag is too narrow, misses on the newest packet.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  localparam int ADDR_W  = 5;
  localparam int PNUM_W  = 10;
  localparam int PART_W  = 2;
  localparam int CTRL_W  = 6;
  localparam int BYTE_W  = 8;
  localparam int NBYTES  = 4;
  localparam int DATA_W  = NBYTES * BYTE_W;
  localparam int GRP_W   = BYTE_W + 1;
  localparam int ENC_W   = NBYTES * GRP_W;
  localparam int HDR_W   = 2 * ADDR_W + PNUM_W + PART_W + CTRL_W;
  localparam int FLIT_W  = HDR_W + ENC_W;

  localparam logic [CTRL_W-1:0] CTRL_NEW   = 6'b000000;
  localparam logic [CTRL_W-1:0] CTRL_PART  = 6'b000001;
  localparam logic [CTRL_W-1:0] CTRL_WHOLE = 6'b000010;

  typedef struct packed {
    logic [PNUM_W-1:0] tag;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [DATA_W-1:0] data;
  } entry_t;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [PNUM_W-1:0] pnum;
    logic [PART_W-1:0] part;
    logic [CTRL_W-1:0] ctrl;
  } hdr_t;
endpackage

// File: rtl/bpt_encoder.sv
module bpt_encoder
  import bpt_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [ENC_W-1:0]  enc
);
  for (genvar g = 0; g < NBYTES; g++) begin : g_grp
    logic [BYTE_W-1:0] b;
    assign b = data[DATA_W-1-g*BYTE_W -: BYTE_W];
    assign enc[ENC_W-1-g*GRP_W -: GRP_W] = {b, ^b};
  end
endmodule

// File: rtl/bpt_store.sv
module bpt_store
  import bpt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  entry_t            wr_entry,
  input  logic              rd_en,
  input  logic [PNUM_W-1:0] rd_pnum,
  output entry_t            rd_entry,
  output logic              rd_vld
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  entry_t           mem [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [IDX_W-1:0] wr_idx, rd_idx;

  assign wr_idx = wr_entry.tag[IDX_W-1:0];
  assign rd_idx = rd_pnum[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_entry;
    if (rd_en) rd_entry <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en) vld_q[wr_idx] <= 1'b1;
      if (rd_en) rd_vld <= vld_q[rd_idx];
    end
  end

  assert_slot_filled_R8: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[$past(wr_idx)]);
endmodule

// File: rtl/bpt_nak_unit.sv
module bpt_nak_unit
  import bpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nak_valid,
  output logic              nak_ready,
  input  logic [ADDR_W-1:0] nak_src,
  input  logic [PNUM_W-1:0] nak_pnum,
  input  logic [PART_W-1:0] nak_part,
  input  logic              nak_whole,
  input  logic              done,
  output logic              take,
  output logic              pend,
  output logic [ADDR_W-1:0] pend_src,
  output logic [PNUM_W-1:0] pend_pnum,
  output logic [PART_W-1:0] pend_part,
  output logic              pend_whole
);
  assign nak_ready = !pend;
  assign take      = nak_valid && nak_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend       <= 1'b0;
      pend_src   <= '0;
      pend_pnum  <= '0;
      pend_part  <= '0;
      pend_whole <= 1'b0;
    end else if (take) begin
      pend       <= 1'b1;
      pend_src   <= nak_src;
      pend_pnum  <= nak_pnum;
      pend_part  <= nak_part;
      pend_whole <= nak_whole;
    end else if (done) begin
      pend <= 1'b0;
    end
  end

  assert_single_nak_R10: assert property (@(posedge clk) disable iff (rst)
    (pend && !done) |=> (pend && $stable(pend_pnum) && $stable(pend_part)));
endmodule

// File: rtl/bpt_sender.sv
module bpt_sender
  import bpt_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [DATA_W-1:0]   in_data,
  input  logic [ADDR_W-1:0]   in_src,
  input  logic [ADDR_W-1:0]   in_dst,
  input  logic                nak_valid,
  output logic                nak_ready,
  input  logic [ADDR_W-1:0]   nak_src,
  input  logic [PNUM_W-1:0]   nak_pnum,
  input  logic [PART_W-1:0]   nak_part,
  input  logic                nak_whole,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [FLIT_W-1:0]   out_flit,
  output logic                nak_err
);
  logic [PNUM_W-1:0] pnum_q;
  logic              advance, accept, hit, done, take;
  logic              pend, pend_whole;
  logic [ADDR_W-1:0] pend_src;
  logic [PNUM_W-1:0] pend_pnum;
  logic [PART_W-1:0] pend_part;
  entry_t            wr_e, rd_e;
  logic              rd_vld;
  logic [ENC_W-1:0]  new_enc, old_enc, re_payload;
  logic [GRP_W-1:0]  grp;
  hdr_t              new_hdr, re_hdr;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance && !pend && !nak_valid;
  assign accept   = in_valid && in_ready;

  bpt_nak_unit u_nak (
    .clk(clk), .rst(rst),
    .nak_valid(nak_valid), .nak_ready(nak_ready),
    .nak_src(nak_src), .nak_pnum(nak_pnum), .nak_part(nak_part),
    .nak_whole(nak_whole), .done(done), .take(take),
    .pend(pend), .pend_src(pend_src), .pend_pnum(pend_pnum),
    .pend_part(pend_part), .pend_whole(pend_whole)
  );

  assign wr_e = '{tag: pnum_q, src: in_src, dst: in_dst, data: in_data};

  bpt_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(accept), .wr_entry(wr_e),
    .rd_en(take), .rd_pnum(nak_pnum),
    .rd_entry(rd_e), .rd_vld(rd_vld)
  );

  bpt_encoder u_enc_new (.data(in_data),   .enc(new_enc));
  bpt_encoder u_enc_old (.data(rd_e.data), .enc(old_enc));

  assign hit  = rd_vld && (rd_e.tag == pend_pnum) && (rd_e.dst == pend_src);
  assign done = pend && (!hit || advance);

  always_comb begin
    grp = '0;
    for (int k = 0; k < NBYTES; k++) begin
      if (pend_part == PART_W'(k)) grp = old_enc[ENC_W-1-k*GRP_W -: GRP_W];
    end
  end

  assign re_payload = pend_whole ? old_enc : {{(ENC_W-GRP_W){1'b0}}, grp};
  assign new_hdr = '{src: in_src, dst: in_dst, pnum: pnum_q, part: '0, ctrl: CTRL_NEW};
  assign re_hdr  = '{src: rd_e.src, dst: rd_e.dst, pnum: rd_e.tag,
                     part: pend_whole ? '0 : pend_part,
                     ctrl: pend_whole ? CTRL_WHOLE : CTRL_PART};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_flit  <= '0;
      pnum_q    <= '0;
      nak_err   <= 1'b0;
    end else begin
      if (advance) out_valid <= 1'b0;
      if (pend) begin
        if (!hit) begin
          nak_err <= 1'b1;
        end else if (advance) begin
          out_valid <= 1'b1;
          out_flit  <= {re_hdr, re_payload};
        end
      end else if (accept) begin
        out_valid <= 1'b1;
        out_flit  <= {new_hdr, new_enc};
        pnum_q    <= pnum_q + 1'b1;
      end
    end
  end

  assert_hold_flit_R4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    nak_err |=> nak_err);
  assert_resend_first_R7: assert property (@(posedge clk) disable iff (rst)
    pend |-> !in_ready);
  assert_one_at_a_time_R10: assert property (@(posedge clk) disable iff (rst)
    take |=> !nak_ready);
endmodule

// File: tb/bpt_sender_tb.sv
module bpt_sender_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic [4:0]  in_src = '0, in_dst = '0;
  logic        nak_valid = 1'b0;
  logic        nak_ready;
  logic [4:0]  nak_src = '0;
  logic [9:0]  nak_pnum = '0;
  logic [1:0]  nak_part = '0;
  logic        nak_whole = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_flit;
  logic        nak_err;

  int checks = 0, failures = 0;
  int cyc = 0;
  logic [63:0] expq[$];
  int          ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        prev_stall = 1'b0;
  logic [63:0] prev_flit = '0;
  logic        mon_on = 1'b0;

  logic [31:0] m_data [1024];
  logic [4:0]  m_src  [1024];
  logic [4:0]  m_dst  [1024];
  int          m_seq  [1024];
  int          nsent = 0;
  logic        m_err = 1'b0;

  bpt_sender u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_src(in_src), .in_dst(in_dst),
    .nak_valid(nak_valid), .nak_ready(nak_ready), .nak_src(nak_src),
    .nak_pnum(nak_pnum), .nak_part(nak_part), .nak_whole(nak_whole),
    .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit),
    .nak_err(nak_err)
  );

  always #10 clk = ~clk;

  function automatic logic [35:0] enc36(logic [31:0] d);
    logic [35:0] r;
    for (int g = 0; g < 4; g++) begin
      logic [7:0] b;
      b = d[31-8*g -: 8];
      r[35-9*g -: 9] = {b, ^b};
    end
    return r;
  endfunction

  function automatic logic [63:0] mk(logic [4:0] s, logic [4:0] t, logic [9:0] p,
                                     logic [1:0] part, logic [5:0] c, logic [35:0] pl);
    return {s, t, p, part, c, pl};
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Output monitor: per-clock reference comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready = (ready_mode == 0) ? 1'b1 : (lfsr[3:2] != 2'b00);
      #1;
      if (mon_on && !rst) begin
        if (prev_stall)
          chk(out_valid && out_flit == prev_flit, "R4", out_flit, prev_flit);
        if (out_valid && out_ready) begin
          if (expq.size() == 0) chk(0, "R1/R5 unexpected flit", out_flit, 64'h0);
          else begin
            logic [63:0] e;
            e = expq.pop_front();
            chk(out_flit == e, "R1/R2/R3/R5/R6 flit", out_flit, e);
          end
        end
        prev_stall = out_valid && !out_ready;
        prev_flit  = out_flit;
      end else prev_stall = 1'b0;
    end
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    chk(0, "watchdog", 64'(cyc), 64'd150000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic send_pkt(logic [31:0] d, logic [4:0] s, logic [4:0] t);
    logic [9:0] p;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_src = s; in_dst = t;
    #2;
    while (!in_ready) begin @(negedge clk); #2; end
    p = 10'(nsent);
    m_data[p] = d; m_src[p] = s; m_dst[p] = t; m_seq[p] = nsent;
    expq.push_back(mk(s, t, p, 2'd0, 6'd0, enc36(d)));
    nsent++;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_nak(logic [9:0] p, logic [4:0] s, logic [1:0] part, logic whole);
    bit hit;
    @(negedge clk);
    nak_valid = 1'b1; nak_pnum = p; nak_src = s; nak_part = part; nak_whole = whole;
    #2;
    while (!nak_ready) begin @(negedge clk); #2; end
    hit = (nsent > 0) && (m_seq[p] >= 0) && (m_seq[p] < nsent) &&
          (nsent - m_seq[p] <= 8) && (10'(m_seq[p]) == p) && (m_dst[p] == s);
    if (hit) begin
      if (whole)
        expq.push_back(mk(m_src[p], m_dst[p], p, 2'd0, 6'b000010, enc36(m_data[p])));
      else begin
        logic [7:0] b;
        b = m_data[p][31-8*part -: 8];
        expq.push_back(mk(m_src[p], m_dst[p], p, part, 6'b000001, {27'd0, b, ^b}));
      end
    end else m_err = 1'b1;
    @(posedge clk); #1;
    nak_valid = 1'b0;
    @(negedge clk); #3;
    chk(nak_ready == 1'b0, "R10 nak_ready low after accept", 64'(nak_ready), 64'd0);
    repeat (2) @(negedge clk);
    #3;
    chk(nak_err == m_err, hit ? "R8 hit keeps error state" : "R9 miss sets nak_err",
        64'(nak_err), 64'(m_err));
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    chk(expq.size() == 0, "R5/R6 all expected flits seen", 64'(expq.size()), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mon_on = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    nsent = 0; m_err = 1'b0; expq.delete();
    for (int i = 0; i < 1024; i++) m_seq[i] = -1;
    #3;
    chk(out_valid == 1'b0, "R11 out_valid reset", 64'(out_valid), 64'd0);
    chk(nak_err == 1'b0, "R11 nak_err reset", 64'(nak_err), 64'd0);
    chk(nak_ready == 1'b1, "R11 nak_ready reset", 64'(nak_ready), 64'd1);
    chk(in_ready == 1'b1, "R11 in_ready reset", 64'(in_ready), 64'd1);
    mon_on = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) m_seq[i] = -1;
    do_reset();

    // R1 R2 R3: varied payloads under random back-pressure
    ready_mode = 1;
    send_pkt(32'h0000_0000, 5'd1, 5'd2);
    send_pkt(32'hFFFF_FFFF, 5'd3, 5'd4);
    send_pkt(32'h0101_0101, 5'd5, 5'd6);
    send_pkt(32'h8000_0001, 5'd7, 5'd8);
    send_pkt(32'h0703_1F7F, 5'd9, 5'd10);
    for (int i = 0; i < 7; i++) send_pkt(32'h1357_9BDF * (i + 3), 5'(i), 5'd20);
    drain();

    // R5: each portion of a recent packet; R6 whole payload
    for (int k = 0; k < 4; k++) send_nak(10'd11, 5'd20, 2'(k), 1'b0);
    send_nak(10'd4, 5'd10, 2'd2, 1'b0);
    send_nak(10'd6, 5'd20, 2'd0, 1'b1);
    drain();

    // R7: NAK and new packet offered together
    fork
      send_nak(10'd9, 5'd20, 2'd3, 1'b0);
      begin
        @(negedge clk); #2;
        chk(in_ready == 1'b0, "R7 in_ready low while NAK offered", 64'(in_ready), 64'd0);
      end
      send_pkt(32'hCAFE_F00D, 5'd30, 5'd31);
    join
    drain();

    // R8 R9: packet 4 is now outside the eight most recent -> miss
    send_nak(10'd4, 5'd10, 2'd1, 1'b0);
    // R9: sticky, and a later hit still re-sends
    send_nak(10'd12, 5'd31, 2'd1, 1'b0);
    drain();

    // R8: destination mismatch misses; R9 never-sent packet
    do_reset();
    send_nak(10'd0, 5'd1, 2'd0, 1'b1);
    do_reset();
    send_pkt(32'h55AA_33CC, 5'd2, 5'd3);
    send_nak(10'd0, 5'd4, 2'd0, 1'b0);
    drain();

    // R3: packet number wraps past 1023
    do_reset();
    ready_mode = 0;
    for (int i = 0; i < 1026; i++) send_pkt(32'(i * 32'h0100_0101), 5'd1, 5'd2);
    ready_mode = 1;
    send_nak(10'd1, 5'd2, 2'd3, 1'b0);
    send_nak(10'd0, 5'd2, 2'd0, 1'b1);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule